// File: doc/BRIEF.md
# Byte-Port Successive-Approximation Readout Controller

This block sequences a 12-bit successive-approximation converter whose result comes out over an 8-bit shared data port. On a start request taken in idle, it issues one full-resolution conversion command and holds off until the converter's busy flag drops. It then reads the result in two byte phases and joins them into one sample. A one-clock strobe marks each new sample.

The two read phases differ only in the byte-select line. With the line low, the converter drives the upper eight result bits. With the line high, it drives the low nibble in the top half of the port and zeros below it. Each read phase keeps the read/convert line high for at least one full clock before the port is sampled, so the converter's output drivers have time to settle. The format-select pin is held low the whole time, which puts the converter into byte-wise output. The sample register changes only when a read sequence completes.

Top module: `sar_byte_reader`

## Requirements
- R1: While rst_ni is low, and right after it rises: chip_sel_n_o=1, rd_conv_o=1, byte_sel_o=0, valid_o=0, sample_o=0. Reset is asynchronous and takes effect at once, even in the middle of a conversion.
- R2: A conversion command (conv_en_o=1, chip_sel_n_o=0, rd_conv_o=0, byte_sel_o=0) is issued for exactly one clock, and only after start_i was sampled high while idle.
- R3: The block never drives chip_sel_n_o=0 with rd_conv_o=0 and byte_sel_o=1, because that combination would start a short conversion. fmt_byte_n_o is always 0.
- R4: While busy_i is high after a command, the block stays waiting and performs no read. A read means chip_sel_n_o=0 with rd_conv_o=1.
- R5: The first read phase drives byte_sel_o=0. It lasts SETTLE_CYC+1 clocks with rd_conv_o=1, and data_i is sampled at the end of it.
- R6: The second read phase follows directly and drives byte_sel_o=1. The low nibble is taken from data_i[7:4].
- R7: sample_o = {first byte, second byte[7:4]}. valid_o is high for exactly one clock per completed read, in the clock where sample_o takes the new value.
- R8: sample_o stays unchanged in every clock in which valid_o is low.
- R9: start_i is ignored outside idle. Holding it high produces back-to-back conversions with exactly one command per sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request |
| busy_i | input | 1 | Converter busy flag |
| data_i | input | 8 | Shared converter data port |
| conv_en_o | output | 1 | Converter enable (high) |
| chip_sel_n_o | output | 1 | Converter select, active low |
| rd_conv_o | output | 1 | High selects read, low selects convert |
| fmt_byte_n_o | output | 1 | Output format select, held low (byte-wise) |
| byte_sel_o | output | 1 | Byte select: 0 upper byte, 1 low nibble |
| sample_o | output | 12 | Assembled sample |
| valid_o | output | 1 | One-clock new-sample strobe |

## Verification
The hardest case to reach from the ports is a request that arrives while a conversion is still running: a long busy window, or a read phase, with start_i already high. The bench holds start_i high across several whole conversions, and its converter model stretches busy for many cycles. It then counts the conversion commands the model receives and compares that count with the samples produced. A reset applied during the busy window covers the abandoned-conversion path.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_WAIT  = 3'd2,
    S_RD_HI = 3'd3,
    S_RD_LO = 3'd4,
    S_LATCH = 3'd5
  } rd_state_e;
endpackage

// File: rtl/sar_rd_seq.sv
module sar_rd_seq
  import sar_rd_pkg::*;
#(
  parameter int SETTLE_CYC = 1
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      busy_i,
  output rd_state_e state_o,
  output logic      cap_hi_o,
  output logic      cap_lo_o,
  output logic      latch_o
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC);

  rd_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic phase_done;

  assign phase_done = (cnt_q == CNT_LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start_i) state_d = S_START;
      S_START: state_d = S_WAIT;
      S_WAIT:  if (!busy_i) state_d = S_RD_HI;
      S_RD_HI: if (phase_done) state_d = S_RD_LO;
      S_RD_LO: if (phase_done) state_d = S_LATCH;
      S_LATCH: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q) cnt_q <= '0;
      else if (state_q == S_RD_HI || state_q == S_RD_LO) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign state_o  = state_q;
  assign cap_hi_o = (state_q == S_RD_HI) && phase_done;
  assign cap_lo_o = (state_q == S_RD_LO) && phase_done;
  assign latch_o  = (state_q == S_LATCH);

  // R2: command lasts one clock and is entered only from idle
  p_start_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_START) |=> (state_q == S_WAIT));
  p_start_from_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_START) |-> ($past(state_q) == S_IDLE));
  // R4: busy holds the wait state
  p_hold_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && busy_i) |=> (state_q == S_WAIT));
  // R5: capture only after a full settle clock in the same read phase
  p_settle_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_hi_o |-> ($past(state_q) == S_RD_HI));
  // R6: low read follows the high read
  p_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_hi_o |=> (state_q == S_RD_LO));
endmodule

// File: rtl/sar_rd_capture.sv
module sar_rd_capture #(
  parameter int BUS_W    = 8,
  parameter int SAMPLE_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cap_hi_i,
  input  logic                cap_lo_i,
  input  logic                latch_i,
  input  logic [BUS_W-1:0]    data_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                valid_o
);
  localparam int LO_W = SAMPLE_W - BUS_W;

  logic [BUS_W-1:0] hi_q;
  logic [LO_W-1:0]  lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q     <= '0;
      lo_q     <= '0;
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      if (cap_hi_i) hi_q <= data_i;
      if (cap_lo_i) lo_q <= data_i[BUS_W-1 -: LO_W];
      valid_o <= latch_i;
      if (latch_i) sample_o <= {hi_q, lo_q};
    end
  end

  // R7: strobe is a single clock
  p_valid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R8: sample held between strobes
  p_sample_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(sample_o));
endmodule

// File: rtl/sar_byte_reader.sv
module sar_byte_reader
  import sar_rd_pkg::*;
#(
  parameter int BUS_W      = 8,
  parameter int SAMPLE_W   = 12,
  parameter int SETTLE_CYC = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                busy_i,
  input  logic [BUS_W-1:0]    data_i,
  output logic                conv_en_o,
  output logic                chip_sel_n_o,
  output logic                rd_conv_o,
  output logic                fmt_byte_n_o,
  output logic                byte_sel_o,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                valid_o
);
  rd_state_e state;
  logic cap_hi, cap_lo, latch;

  sar_rd_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .busy_i   (busy_i),
    .state_o  (state),
    .cap_hi_o (cap_hi),
    .cap_lo_o (cap_lo),
    .latch_o  (latch)
  );

  sar_rd_capture #(.BUS_W(BUS_W), .SAMPLE_W(SAMPLE_W)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_hi_i (cap_hi),
    .cap_lo_i (cap_lo),
    .latch_i  (latch),
    .data_i   (data_i),
    .sample_o (sample_o),
    .valid_o  (valid_o)
  );

  // Pin decode; converter is deselected except in command and read phases
  always_comb begin
    conv_en_o    = 1'b1;
    fmt_byte_n_o = 1'b0;
    chip_sel_n_o = 1'b1;
    rd_conv_o    = 1'b1;
    byte_sel_o   = 1'b0;
    unique case (state)
      S_START: begin chip_sel_n_o = 1'b0; rd_conv_o = 1'b0; end
      S_RD_HI: chip_sel_n_o = 1'b0;
      S_RD_LO: begin chip_sel_n_o = 1'b0; byte_sel_o = 1'b1; end
      S_LATCH: byte_sel_o = 1'b1;
      default: ;
    endcase
  end

  // R3: never issue a short-conversion command
  p_no_short_conv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!chip_sel_n_o && !rd_conv_o && byte_sel_o));
  // R4: no read while converter is busy
  p_no_read_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chip_sel_n_o && rd_conv_o) |-> !busy_i);
endmodule

// File: tb/sar_byte_reader_bench.sv
module sar_byte_reader_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy = 1'b0;
  logic [7:0]  data;
  logic        ce, cs_n, rc, k8n, a0, valid;
  logic [11:0] sample;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int busy_len = 5, busy_cnt = 0, cmd_cnt = 0, short_cnt = 0, busy_read_cnt = 0;
  logic [11:0] conv_val = 12'h000;

  always #2.5 clk = ~clk;

  sar_byte_reader u_sar_byte_reader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_i(busy), .data_i(data),
    .conv_en_o(ce), .chip_sel_n_o(cs_n), .rd_conv_o(rc), .fmt_byte_n_o(k8n),
    .byte_sel_o(a0), .sample_o(sample), .valid_o(valid)
  );

  // Converter model
  always_comb begin
    if (ce && !cs_n && rc) data = a0 ? {conv_val[3:0], 4'h0} : conv_val[11:4];
    else data = 8'h5A;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ce && !cs_n && !rc && a0) short_cnt <= short_cnt + 1;
    if (ce && !cs_n && rc && busy) busy_read_cnt <= busy_read_cnt + 1;
    if (ce && !cs_n && !rc && !a0) begin
      cmd_cnt  <= cmd_cnt + 1;
      busy     <= 1'b1;
      busy_cnt <= busy_len;
    end else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    else busy <= 1'b0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_valid(output bit got);
    got = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (valid) begin got = 1; break; end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    @(negedge clk);
    chk(cs_n == 1 && rc == 1 && a0 == 0, "R1 pins in reset", {cs_n, rc, a0}, 3'b110);
    chk(valid == 0 && sample == 0, "R1 outputs in reset", sample, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1 && valid == 0, "R1 after release", {cs_n, valid}, 2'b10);
    chk(k8n == 0, "R3 format pin low", k8n, 0);
  endtask

  task automatic t_convert(input logic [11:0] v, input int blen);
    int c0;
    int wait_cyc;
    bit got;
    logic [11:0] held;
    conv_val = v;
    busy_len = blen;
    c0 = cmd_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(ce && !cs_n && !rc && !a0, "R2 command pins", {ce, cs_n, rc, a0}, 4'b1000);
    @(negedge clk);
    chk(!(!cs_n && !rc), "R2 command one clock", {cs_n, rc}, 2'b11);
    wait_cyc = 0;
    while (busy) begin
      chk(!( !cs_n && rc), "R4 no read while busy", {cs_n, rc}, 2'b11);
      @(negedge clk);
      wait_cyc++;
    end
    chk(wait_cyc >= blen, "R4 waited busy window", wait_cyc, blen);
    wait_valid(got);
    chk(got, "R7 strobe seen", got, 1);
    chk(sample == v, "R7 sample value", sample, v);
    chk(cmd_cnt - c0 == 1, "R2 one command", cmd_cnt - c0, 1);
    held = sample;
    @(negedge clk);
    chk(!valid, "R7 strobe one clock", valid, 0);
    conv_val = ~v;
    repeat (3) @(negedge clk);
    chk(sample == held, "R8 sample stable", sample, held);
  endtask

  // R5/R6: check read phase timing directly
  task automatic t_phases();
    int hi_n, lo_n;
    bit got;
    conv_val = 12'h6B9;
    busy_len = 2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!( !cs_n && rc)) @(negedge clk);
    hi_n = 0;
    while (!cs_n && rc && !a0) begin hi_n++; @(negedge clk); end
    chk(hi_n == 2, "R5 high read length", hi_n, 2);
    lo_n = 0;
    while (!cs_n && rc && a0) begin lo_n++; @(negedge clk); end
    chk(lo_n == 2, "R6 low read follows, length", lo_n, 2);
    wait_valid(got);
    chk(got && sample == 12'h6B9, "R6 nibble from top bits", sample, 12'h6B9);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_hold_start();
    int c0, nval;
    bit got;
    c0 = cmd_cnt;
    nval = 0;
    busy_len = 12;
    conv_val = 12'hC35;
    start = 1'b1;
    for (int k = 0; k < 3; k++) begin
      wait_valid(got);
      if (got) nval++;
      chk(sample == 12'hC35, "R9 sample under held start", sample, 12'hC35);
    end
    start = 1'b0;
    repeat (4) @(negedge clk);
    if (cs_n == 1'b1 && !busy) ;
    chk(cmd_cnt - c0 == nval || cmd_cnt - c0 == nval + 1, "R9 commands per sample",
        cmd_cnt - c0, nval);
    wait_valid(got);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_mid();
    int c0;
    busy_len = 30;
    conv_val = 12'h111;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(cs_n == 1 && valid == 0 && sample == 0, "R1 async reset mid-conversion", sample, 0);
    @(negedge clk);
    rst_n = 1'b1;
    c0 = cmd_cnt;
    repeat (40) @(negedge clk);
    chk(cmd_cnt == c0 && valid == 0, "R2 no command without request", cmd_cnt - c0, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_convert(12'hA5C, 5);
    t_convert(12'h000, 1);
    t_convert(12'hFFF, 20);
    t_convert(12'h3C1, 3);
    t_phases();
    t_hold_start();
    t_reset_mid();
    chk(short_cnt == 0, "R3 no short conversion command", short_cnt, 0);
    chk(busy_read_cnt == 0, "R4 no read during busy", busy_read_cnt, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 50000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected <50000 cycles", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule